// File: doc/BRIEF.md
# DS3 Frame Timing Reference Generator

This block turns a 44.736 MHz bit-rate clock into a free-running DS3 M-frame timing reference for bit-serial terminal equipment. A qualifier input, `tick_en`, marks the clock cycles that carry a line bit. For every qualified cycle the block emits one reference bit, one cycle later, together with a bit strobe (`bit_ce`), an active-low frame strobe on the first bit of the M-frame and an active-low gap strobe on the first bit of every 85-bit block.

The data output is a framing skeleton. It carries the F and M alignment bits at their positions. Every other position is driven low: the X, P and C overhead bits and all payload bits. A downstream mapper can use the strobes to place payload and overhead. It can OR its own bits onto the skeleton without recovering frame alignment.

The output is a push stream qualified by `bit_ce` and has no back-pressure. The consumer must accept a bit on every cycle where `bit_ce` is high, because the reference never stalls except when `tick_en` is low. A frame is 7 subframes of 8 blocks of 85 bits, which is 4760 bits. The position counters wrap with no idle bits between frames.

Top module: `ds3_ref_gen`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the following cycle shows `bit_ce`=0, `frame_n`=1, `gap_n`=1 and `ref_data`=0. The internal position returns to bit 1 of block 1 of subframe 1.
- R2: A cycle with `tick_en`=1 and no reset produces `bit_ce`=1 on the next cycle. A cycle with `tick_en`=0 produces `bit_ce`=0, `frame_n`=1, `gap_n`=1 and `ref_data`=0 on the next cycle, and the position holds.
- R3: `frame_n` is 0 only for the bit at subframe 1, block 1, bit 1, which is once per frame.
- R4: `gap_n` is 0 for bit 1 of every block. Consecutive gap strobes are exactly 85 emitted bits apart, giving 56 per frame.
- R5: The overhead bit of blocks 2, 4, 6 and 8 in every subframe (the F-bits) carries 1, 0, 0, 1 respectively.
- R6: The overhead bit of block 1 in subframes 5, 6 and 7 (the M-bits) carries 0, 1, 0 respectively.
- R7: Every other bit is emitted as 0. This covers the block 1 overhead in subframes 1 to 4, the block 3, 5 and 7 overhead, and all payload bits.
- R8: The first emitted bit after reset carries the frame strobe.
- R9: Consecutive frame strobes are exactly 4760 emitted bits apart, with no idle positions at the frame wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 44.736 MHz bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Qualifies the cycle as one line bit |
| bit_ce | output | 1 | High when the outputs carry a reference bit |
| frame_n | output | 1 | Active-low strobe on the first bit of the M-frame |
| gap_n | output | 1 | Active-low strobe on the first bit of each 85-bit block |
| ref_data | output | 1 | Framing skeleton bit: F and M values, zero elsewhere |

## Verification
Several properties are checked on every cycle. These are the cycle latency from `tick_en` to `bit_ce`, the idle values of the strobes without `bit_ce`, and the nesting of the frame strobe inside a gap strobe with zero data. The 85-bit gap spacing, the 4760-bit frame spacing and the frame strobe on the first bit after reset are also checked continuously, through counters in the checker. The F and M bit values at each overhead position, and the zeros on the X, P and C positions, can only be shown by the bench's scenarios. The bench compares every emitted bit against a position model under random qualifier patterns and mid-frame resets.

// File: rtl/ds3_ref_pkg.sv
package ds3_ref_pkg;
  localparam int unsigned DEF_BLOCK_BITS = 85;
  localparam int unsigned DEF_BLOCKS     = 8;
  localparam int unsigned DEF_SUBFRAMES  = 7;

  // Registered output bundle of the generator
  typedef struct packed {
    logic ce;
    logic frame_n;
    logic gap_n;
    logic data;
  } ref_out_t;

  localparam ref_out_t REF_IDLE = '{ce: 1'b0, frame_n: 1'b1, gap_n: 1'b1, data: 1'b0};
endpackage

// File: rtl/ds3_ref_modcnt.sv
module ds3_ref_modcnt #(
  parameter int unsigned MOD = 85,
  localparam int unsigned W  = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = (cnt == W'(MOD - 1));

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/ds3_ref_decode.sv
module ds3_ref_decode #(
  parameter int unsigned BLOCK_BITS = 85,
  parameter int unsigned BLOCKS     = 8,
  parameter int unsigned SUBFRAMES  = 7,
  parameter logic [BLOCKS/2-1:0] F_PATTERN = 4'b1001,
  parameter logic [2:0]          M_PATTERN = 3'b010,
  localparam int unsigned BW = $clog2(BLOCK_BITS),
  localparam int unsigned KW = $clog2(BLOCKS),
  localparam int unsigned SW = $clog2(SUBFRAMES),
  localparam int unsigned FN = BLOCKS / 2,
  localparam int unsigned M0 = SUBFRAMES - 3
) (
  input  logic [BW-1:0] bit_idx,
  input  logic [KW-1:0] blk_idx,
  input  logic [SW-1:0] sub_idx,
  output logic          is_frame,
  output logic          is_gap,
  output logic          skel_bit
);
  logic f_hit, m_hit;

  assign is_gap   = (bit_idx == '0);
  assign is_frame = is_gap && (blk_idx == '0) && (sub_idx == '0);

  // F alignment bits sit on odd blocks; bit i of F_PATTERN is the i-th F-bit
  always_comb begin
    f_hit = 1'b0;
    for (int i = 0; i < FN; i++)
      if (blk_idx == KW'(2 * i + 1)) f_hit = F_PATTERN[i];
  end

  // M alignment bits sit on block 0 of the last three subframes
  always_comb begin
    m_hit = 1'b0;
    if (blk_idx == '0)
      for (int i = 0; i < 3; i++)
        if (sub_idx == SW'(M0 + i)) m_hit = M_PATTERN[i];
  end

  assign skel_bit = is_gap && (f_hit || m_hit);
endmodule

// File: rtl/ds3_ref_outreg.sv
module ds3_ref_outreg
  import ds3_ref_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv,
  input  logic     is_frame,
  input  logic     is_gap,
  input  logic     skel_bit,
  output ref_out_t q
);
  ref_out_t d;

  always_comb begin
    d = REF_IDLE;
    if (adv) begin
      d.ce      = 1'b1;
      d.frame_n = ~is_frame;
      d.gap_n   = ~is_gap;
      d.data    = skel_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= REF_IDLE;
    else     q <= d;
  end
endmodule

// File: rtl/ds3_ref_gen.sv
module ds3_ref_gen
  import ds3_ref_pkg::*;
#(
  parameter int unsigned BLOCK_BITS = DEF_BLOCK_BITS,
  parameter int unsigned BLOCKS     = DEF_BLOCKS,
  parameter int unsigned SUBFRAMES  = DEF_SUBFRAMES,
  parameter logic [BLOCKS/2-1:0] F_PATTERN = 4'b1001,
  parameter logic [2:0]          M_PATTERN = 3'b010
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic bit_ce,
  output logic frame_n,
  output logic gap_n,
  output logic ref_data
);
  localparam int unsigned BW = $clog2(BLOCK_BITS);
  localparam int unsigned KW = $clog2(BLOCKS);
  localparam int unsigned SW = $clog2(SUBFRAMES);

  logic [BW-1:0] bit_idx;
  logic [KW-1:0] blk_idx;
  logic [SW-1:0] sub_idx;
  logic bit_last, blk_last, sub_last;
  logic is_frame, is_gap, skel_bit;
  ref_out_t q;

  ds3_ref_modcnt #(.MOD(BLOCK_BITS)) u_bit (
    .clk(clk), .rst(rst), .inc(tick_en), .cnt(bit_idx), .last(bit_last));

  ds3_ref_modcnt #(.MOD(BLOCKS)) u_blk (
    .clk(clk), .rst(rst), .inc(tick_en && bit_last), .cnt(blk_idx), .last(blk_last));

  ds3_ref_modcnt #(.MOD(SUBFRAMES)) u_sub (
    .clk(clk), .rst(rst), .inc(tick_en && bit_last && blk_last),
    .cnt(sub_idx), .last(sub_last));

  ds3_ref_decode #(
    .BLOCK_BITS(BLOCK_BITS), .BLOCKS(BLOCKS), .SUBFRAMES(SUBFRAMES),
    .F_PATTERN(F_PATTERN), .M_PATTERN(M_PATTERN)
  ) u_dec (
    .bit_idx(bit_idx), .blk_idx(blk_idx), .sub_idx(sub_idx),
    .is_frame(is_frame), .is_gap(is_gap), .skel_bit(skel_bit));

  ds3_ref_outreg u_out (
    .clk(clk), .rst(rst), .adv(tick_en),
    .is_frame(is_frame), .is_gap(is_gap), .skel_bit(skel_bit), .q(q));

  assign bit_ce   = q.ce;
  assign frame_n  = q.frame_n;
  assign gap_n    = q.gap_n;
  assign ref_data = q.data;

  logic unused_wrap;
  assign unused_wrap = sub_last;
endmodule

// File: rtl/ds3_ref_gen_chk.sv
module ds3_ref_gen_chk #(
  parameter int unsigned BLOCK_BITS = 85,
  parameter int unsigned BLOCKS     = 8,
  parameter int unsigned SUBFRAMES  = 7,
  localparam int unsigned FRAME_BITS = BLOCK_BITS * BLOCKS * SUBFRAMES,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic bit_ce,
  input logic frame_n,
  input logic gap_n,
  input logic ref_data
);
  logic [CW-1:0] gap_cnt, frm_cnt;
  logic gap_seen, frm_seen, first_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0; frm_cnt <= '0;
      gap_seen <= 1'b0; frm_seen <= 1'b0; first_pending <= 1'b1;
    end else if (bit_ce) begin
      first_pending <= 1'b0;
      if (!gap_n) begin gap_cnt <= CW'(1); gap_seen <= 1'b1; end
      else gap_cnt <= gap_cnt + CW'(1);
      if (!frame_n) begin frm_cnt <= CW'(1); frm_seen <= 1'b1; end
      else frm_cnt <= frm_cnt + CW'(1);
    end
  end

  p_ce_tracks_en_r2: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> bit_ce);
  p_ce_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> !bit_ce);
  p_idle_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_ce |-> (frame_n && gap_n && !ref_data));
  p_frame_in_gap_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_n |-> !gap_n);
  p_frame_no_data_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_n |-> !ref_data);
  p_gap_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_ce && !gap_n && gap_seen) |-> (gap_cnt == CW'(BLOCK_BITS)));
  p_frame_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    (bit_ce && !frame_n && frm_seen) |-> (frm_cnt == CW'(FRAME_BITS)));
  p_first_is_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_ce && first_pending) |-> !frame_n);
endmodule

bind ds3_ref_gen ds3_ref_gen_chk #(
  .BLOCK_BITS(BLOCK_BITS), .BLOCKS(BLOCKS), .SUBFRAMES(SUBFRAMES)
) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bit_ce(bit_ce),
  .frame_n(frame_n), .gap_n(gap_n), .ref_data(ref_data));

// File: tb/sim_ds3_ref_gen.sv
module sim_ds3_ref_gen;
  localparam time CLK_PERIOD = 22ns;
  localparam int FRAME = 4760;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
  logic bit_ce, frame_n, gap_n, ref_data;

  int checks = 0, fails = 0, cyc = 0;
  int b = 0, k = 0, s = 0;
  int since_frame = -1;
  bit first_after_rst = 1'b1;
  bit done = 1'b0;

  ds3_ref_gen u0 (.clk(clk), .rst(rst), .tick_en(tick_en), .bit_ce(bit_ce),
                  .frame_n(frame_n), .gap_n(gap_n), .ref_data(ref_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_bit(int bi, int bk, int bs);
    if (bi != 0) return 1'b0;
    if (bk == 1 || bk == 7) return 1'b1;   // F1, F4
    if (bk == 0 && bs == 5) return 1'b1;   // M2
    return 1'b0;
  endfunction

  function automatic string data_tag(int bi, int bk, int bs);
    if (bi == 0 && bk[0]) return "R5";
    if (bi == 0 && bk == 0 && bs >= 4) return "R6";
    return "R7";
  endfunction

  task automatic chk(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (pos sub=%0d blk=%0d bit=%0d)",
               tag, what, act, expv, s, k, b);
    end
  endtask

  task automatic step(bit en_v, bit rst_v);
    tick_en = en_v; rst = rst_v;
    @(posedge clk); @(negedge clk);
    cyc++;
    if (rst_v) begin
      chk("R1", bit_ce, 1'b0, "bit_ce"); chk("R1", frame_n, 1'b1, "frame_n");
      chk("R1", gap_n, 1'b1, "gap_n");   chk("R1", ref_data, 1'b0, "ref_data");
      b = 0; k = 0; s = 0; since_frame = -1; first_after_rst = 1'b1;
    end else if (en_v) begin
      bit fr;
      fr = (b == 0 && k == 0 && s == 0);
      chk("R2", bit_ce, 1'b1, "bit_ce");
      chk(first_after_rst ? "R8" : "R3", frame_n, !fr, "frame_n");
      chk("R4", gap_n, !(b == 0), "gap_n");
      chk(data_tag(b, k, s), ref_data, exp_bit(b, k, s), "ref_data");
      if (fr) begin
        if (since_frame >= 0) begin
          checks++;
          if (since_frame != FRAME) begin
            fails++;
            $display("FAIL R9 frame spacing: actual %0d expected %0d", since_frame, FRAME);
          end
        end
        since_frame = 0;
      end
      if (since_frame >= 0) since_frame++;
      first_after_rst = 1'b0;
      b++;
      if (b == 85) begin b = 0; k++; end
      if (k == 8) begin k = 0; s++; end
      if (s == 7) s = 0;
    end else begin
      chk("R2", bit_ce, 1'b0, "bit_ce idle"); chk("R2", frame_n, 1'b1, "frame_n idle");
      chk("R2", gap_n, 1'b1, "gap_n idle");   chk("R2", ref_data, 1'b0, "ref_data idle");
    end
  endtask

  initial begin
    void'($urandom(32'd4417));
    @(negedge clk);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);                      // reset wins over enable (R1)
    // two back-to-back frames at full rate (R3..R9)
    for (int i = 0; i < 2 * FRAME + 10; i++) step(1'b1, 1'b0);
    // random qualifier, about three of four cycles enabled
    for (int i = 0; i < 6000; i++) step(($urandom % 4) != 0, 1'b0);
    // mid-frame reset with enable held, then first bit must be frame start (R8)
    step(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    for (int i = 0; i < FRAME + 200; i++) step(($urandom % 8) != 0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule